// File: doc/BRIEF.md
# Black-Level Clamp Controller

This block is the digital half of a black-level clamp loop for an image sensor front end. On every line a strobe marks the shielded (optically black) pixels. While the strobe is high, the block compares each 10-bit ADC sample against a programmable black target held in quarter-LSB units and sums the differences. When the strobe drops, the sum is divided by the number of pixels seen. The resulting average error is scaled down by a power-of-two gain and added to a signed correction word. That word drives an offset DAC ahead of the converter.

Two byte-wide registers are written through a plain write port. One holds the black target. The other holds the loop-off bit, the line divider and the gain shift. The line divider lets the loop act on only every Nth line, which slows it down. With the loop switched off, the output shows the target itself as a fixed offset, and the correction the loop has built up is kept unchanged.

Top module: `black_clamp_loop`

## Requirements
- R1: After reset both registers read zero, so the loop is on with N=1 and gain shift 0, and corr_o is 0.
- R2: A write with address 0 loads the black target (8 bits, unit 0.25 LSB). A write with address 1 loads the mode byte: bit 0 is loop-off, bits 4:1 hold N-1, bits 7:5 hold the gain shift k. A write takes effect at the clock edge where cfg_we_i is high.
- R3: Only samples taken on cycles with clamp_win_i high contribute. Sample values on other cycles have no effect on corr_o.
- R4: For each contributing pixel the error is target - 4*sample. On the cycle clamp_win_i falls, the error sum is divided by the pixel count, truncating toward zero. The quotient is shifted right arithmetically by k and added to the correction. The new value appears on corr_o no later than 24 cycles after the fall.
- R5: The correction is a 12-bit two's-complement word. It saturates at -2048 and +2047 instead of wrapping.
- R6: The correction is updated on only every Nth window fall counted from reset, loop enable or the last update. N=1 means every line. On the other lines corr_o is unchanged.
- R7: While loop-off is set, corr_o equals the target zero-extended, the stored correction is frozen and the line count is held at zero. Clearing loop-off restores the frozen correction on corr_o.
- R8: A window counts at most 255 pixels. Pixels past the 255th in the same window are ignored.
- R9: A target write in the same cycle as a window pixel takes effect only for later pixels. That pixel uses the previous target.
- R10: A window of one pixel still yields a full update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register select: 0 target, 1 mode |
| cfg_wdata_i | input | 8 | Register write data |
| clamp_win_i | input | 1 | High on shielded pixels of a line |
| sample_i | input | 10 | ADC sample, one per clock |
| corr_o | output | 12 | Signed correction word for the offset DAC |

## Verification
A target write can land on the same clock as a pixel that is being summed. The design must then count that pixel against the old target and every later pixel against the new one. The bench provokes this by raising cfg_we_i in the middle of a window, on the cycle of one chosen pixel. Its model splits the error sum at that pixel, and the check compares corr_o after the update against that split sum. A model that applied the new target one pixel early or late would give a different result.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int REF_W = 8;
  localparam int CFG_DW = 8;
  localparam logic ADDR_REF = 1'b0;
  localparam logic ADDR_MODE = 1'b1;

  typedef struct packed {
    logic [REF_W-1:0] ref_lvl;
    logic [2:0]       gain_k;
    logic [3:0]       div_m1;
    logic             loop_off;
  } cfg_t;
endpackage

// File: rtl/blc_cfg_regs.sv
module blc_cfg_regs
  import blc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output cfg_t              cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_REF) cfg_o.ref_lvl <= wdata_i;
      else {cfg_o.gain_k, cfg_o.div_m1, cfg_o.loop_off} <= wdata_i;
    end
  end
endmodule

// File: rtl/blc_err_accum.sv
module blc_err_accum
  import blc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CNT_W    = 8,
  localparam int ERR_W   = SAMPLE_W + 3,
  localparam int AW      = ERR_W + CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                win_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [REF_W-1:0]    ref_i,
  input  logic                loop_off_i,
  input  logic [3:0]          div_m1_i,
  output logic                go_o,
  output logic signed [AW-1:0] sum_o,
  output logic [CNT_W-1:0]    cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                    win_q, fall;
  logic signed [ERR_W-1:0] err;
  logic signed [AW-1:0]    sum_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [3:0]              line_q;

  assign fall = win_q & ~win_i;
  // error in quarter-LSB units
  assign err  = $signed({{(ERR_W-REF_W){1'b0}}, ref_i}) - $signed({1'b0, sample_i, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      sum_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_i;
      if (fall) begin
        sum_q <= '0;
        cnt_q <= '0;
      end else if (win_i && cnt_q != CNT_MAX) begin
        sum_q <= sum_q + {{(AW-ERR_W){err[ERR_W-1]}}, err};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         line_q <= '0;
    else if (loop_off_i) line_q <= '0;
    else if (fall)       line_q <= (line_q >= div_m1_i) ? 4'd0 : line_q + 4'd1;
  end

  assign go_o  = fall & ~loop_off_i & (line_q >= div_m1_i);
  assign sum_o = sum_q;
  assign cnt_o = cnt_q;

  p_fall_has_pixels_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |-> cnt_q != '0);
  p_cap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || !win_q) && ($stable(sum_q) || !win_q));
  p_outside_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_i && !win_q) |=> $stable(sum_q));
endmodule

// File: rtl/blc_div.sv
module blc_div #(
  parameter int NUM_W = 21,
  parameter int DEN_W = 8,
  localparam int IT_W = $clog2(NUM_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0]        den_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [NUM_W-1:0] quo_o
);
  logic [NUM_W-1:0] quo_q, mag;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [DEN_W:0]   rem_sh, rem_sub;
  logic [IT_W-1:0]  it_q;
  logic             busy_q, done_q, neg_q, fits;

  assign mag     = num_i[NUM_W-1] ? NUM_W'(-num_i) : NUM_W'(num_i);
  assign rem_sh  = {rem_q, quo_q[NUM_W-1]};
  assign fits    = rem_sh >= {1'b0, den_q};
  assign rem_sub = rem_sh - {1'b0, den_q};

  // restoring divide on magnitudes, one quotient bit per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        quo_q  <= mag;
        rem_q  <= '0;
        den_q  <= den_i;
        neg_q  <= num_i[NUM_W-1];
        it_q   <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        if (it_q == IT_W'(NUM_W-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          it_q <= it_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = neg_q ? -$signed(quo_q) : $signed(quo_q);

  p_no_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
  p_done_after_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(busy_q));
endmodule

// File: rtl/blc_iir_update.sv
module blc_iir_update #(
  parameter int Q_W    = 21,
  parameter int CORR_W = 12,
  localparam int SW    = Q_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     done_i,
  input  logic signed [Q_W-1:0]    quo_i,
  input  logic [2:0]               gain_k_i,
  input  logic                     loop_off_i,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam logic signed [SW-1:0] C_MAX = SW'((64'sd1 <<< (CORR_W-1)) - 1);
  localparam logic signed [SW-1:0] C_MIN = -C_MAX - SW'(1);

  logic signed [CORR_W-1:0] corr_q;
  logic signed [Q_W-1:0]    step;
  logic signed [SW-1:0]     nxt;

  assign step = quo_i >>> gain_k_i;
  assign nxt  = SW'(corr_q) + SW'(step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q <= '0;
    end else if (done_i && !loop_off_i) begin
      if (nxt > C_MAX)      corr_q <= CORR_W'(C_MAX);
      else if (nxt < C_MIN) corr_q <= CORR_W'(C_MIN);
      else                  corr_q <= CORR_W'(nxt);
    end
  end

  assign corr_o = corr_q;

  p_freeze_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_off_i |=> $stable(corr_q));
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(corr_q));
  p_sat_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !loop_off_i && step > 0 && corr_q == CORR_W'(C_MAX)) |=> corr_q == CORR_W'(C_MAX));
endmodule

// File: rtl/black_clamp_loop.sv
module black_clamp_loop
  import blc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CNT_W    = 8,
  parameter int CORR_W   = 12,
  localparam int ERR_W   = SAMPLE_W + 3,
  localparam int AW      = ERR_W + CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic                cfg_addr_i,
  input  logic [CFG_DW-1:0]   cfg_wdata_i,
  input  logic                clamp_win_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [CORR_W-1:0]   corr_o
);
  cfg_t                     cfg;
  logic                     go, start, busy, done;
  logic signed [AW-1:0]     sum, quo;
  logic [CNT_W-1:0]         cnt;
  logic signed [CORR_W-1:0] corr_q;

  blc_cfg_regs u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .cfg_o(cfg)
  );

  blc_err_accum #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_acc (
    .clk_i, .rst_ni, .win_i(clamp_win_i), .sample_i, .ref_i(cfg.ref_lvl),
    .loop_off_i(cfg.loop_off), .div_m1_i(cfg.div_m1), .go_o(go), .sum_o(sum), .cnt_o(cnt)
  );

  // a fall during a running divide is dropped
  assign start = go & ~busy;

  blc_div #(.NUM_W(AW), .DEN_W(CNT_W)) u_div (
    .clk_i, .rst_ni, .start_i(start), .num_i(sum), .den_i(cnt),
    .busy_o(busy), .done_o(done), .quo_o(quo)
  );

  blc_iir_update #(.Q_W(AW), .CORR_W(CORR_W)) u_iir (
    .clk_i, .rst_ni, .done_i(done), .quo_i(quo), .gain_k_i(cfg.gain_k),
    .loop_off_i(cfg.loop_off), .corr_o(corr_q)
  );

  assign corr_o = cfg.loop_off ? {{(CORR_W-REF_W){1'b0}}, cfg.ref_lvl} : corr_q;
endmodule

// File: tb/black_clamp_loop_tb_top.sv
`timescale 1ns/1ps
module black_clamp_loop_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic       win = 1'b0;
  logic [9:0] sample = '0;
  logic [11:0] corr;

  always #2.5 clk = ~clk;

  black_clamp_loop dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .clamp_win_i(win), .sample_i(sample), .corr_o(corr)
  );

  typedef struct { int exp; string tag; } item_t;
  item_t q[$];
  event  sample_ev;
  int    n_chk = 0, n_err = 0;
  bit    finished = 0;

  // reference model state
  int m_ref = 0, m_off = 0, m_n = 1, m_k = 0, m_lc = 0, m_c = 0;

  initial begin
    forever begin
      @(sample_ev);
      if (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = $signed(corr);
        n_chk++;
        if (act != it.exp) begin
          n_err++;
          $display("FAIL %s: corr_o=%0d expected %0d", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_now(input string tag);
    item_t it;
    it.exp = m_off ? m_ref : m_c;
    it.tag = tag;
    q.push_back(it);
    -> sample_ev;
    @(negedge clk);
  endtask

  task automatic cfg_wr(input bit a, input int d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = 8'(d);
    @(negedge clk);
    we = 1'b0;
    if (a == 1'b0) m_ref = d;
    else begin
      m_off = d & 1;
      m_n   = ((d >> 1) & 15) + 1;
      m_k   = (d >> 5) & 7;
      if (m_off) m_lc = 0;
    end
  endtask

  // one line: garbage, window of npix alternating sa/sb, optional target write at pixel wr_pix
  task automatic run_line(input int npix, input int sa, input int sb,
                          input int wr_pix, input int wr_val, input string tag);
    int sum = 0, r = m_ref, cnt, qv, st;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      win = 1'b0; sample = 10'(1023 - i * 211);
    end
    for (int i = 0; i < npix; i++) begin
      int s = (i % 2) ? sb : sa;
      @(negedge clk);
      win = 1'b1; sample = 10'(s);
      if (i == wr_pix) begin we = 1'b1; addr = 1'b0; wdata = 8'(wr_val); end
      else we = 1'b0;
      if (i < 255) sum += r - 4 * s;
      if (i == wr_pix) r = wr_val;
    end
    @(negedge clk);
    win = 1'b0; we = 1'b0; sample = 10'd777;
    if (wr_pix >= 0) m_ref = wr_val;
    if (m_off) m_lc = 0;
    else if (m_lc >= m_n - 1) begin
      m_lc = 0;
      cnt = (npix < 255) ? npix : 255;
      qv = sum / cnt;
      st = qv >>> m_k;
      m_c = m_c + st;
      if (m_c > 2047) m_c = 2047;
      if (m_c < -2048) m_c = -2048;
    end else m_lc++;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      sample = 10'((i * 37) % 1024);
    end
    expect_now(tag);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1");
    cfg_wr(1'b0, 40);
    expect_now("R2");
    run_line(24, 5, 5, -1, 0, "R3");
    cfg_wr(1'b1, 8'h40);
    run_line(3, 12, 13, -1, 0, "R4");
    cfg_wr(1'b1, 8'h04);
    run_line(6, 2, 2, -1, 0, "R6");
    run_line(6, 2, 2, -1, 0, "R6");
    run_line(6, 2, 2, -1, 0, "R6");
    cfg_wr(1'b1, 8'h00);
    run_line(1, 20, 20, -1, 0, "R10");
    run_line(300, 0, 1023, -1, 0, "R8");
    run_line(8, 10, 10, 3, 100, "R9");
    cfg_wr(1'b1, 8'h01);
    expect_now("R7");
    run_line(10, 0, 0, -1, 0, "R7");
    cfg_wr(1'b0, 7);
    expect_now("R7");
    cfg_wr(1'b1, 8'h00);
    expect_now("R7");
    cfg_wr(1'b0, 0);
    run_line(20, 1023, 1023, -1, 0, "R5");
    cfg_wr(1'b0, 255);
    for (int i = 0; i < 18; i++) run_line(4, 0, 0, -1, 0, "R5");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule